// File: doc/BRIEF.md
# Slow Module Sample Repeat Buffer

This block couples a slow converting input channel to a faster shared sample clock. The converter reports each finished conversion with a one-cycle done strobe and its data word. The sample clock arrives as a one-cycle tick. On every tick the block returns the most recent held conversion. When no new conversion has finished since the last tick, it returns the held value again. Each returned word carries a flag that says whether the word is fresh or a repeat. For example, with ten ticks for every conversion, each point comes out once as fresh and then nine times as a repeat.

A task begins with a commit pulse. The commit takes a snapshot of the latest conversion and uses it as the first point. From then on, ticks return that point until the start trigger has fired and a later conversion has finished. That conversion becomes the second point, and so on. In single-point mode nothing is ever repeated: a tick that finds no unread conversion waits for the next one. All results are registered and appear one cycle after the clock edge that caused them.

Top module: `slow_repeat_buf`

## Requirements
- R1: While `rst_ni` is low, and after reset until the first output, `smp_valid_o`, `smp_fresh_o` and `smp_data_o` are all zero.
- R2: Before the first commit, ticks produce no output (`smp_valid_o` stays low), whatever conversions arrive.
- R3: A commit takes the most recent conversion as the held point. If a conversion finishes in the commit cycle, its data is used. The first tick after the commit returns this point with `smp_fresh_o`=1, one cycle after the tick edge.
- R4: A tick with no new conversion since the previous returned sample returns the held data again with `smp_fresh_o`=0.
- R5: Conversions that finish after a commit but before the start trigger do not change the held point.
- R6: After the start trigger, each finished conversion replaces the held point. The next tick returns it with `smp_fresh_o`=1.
- R7: A conversion that finishes in the same cycle as a tick is returned by that tick, marked fresh.
- R8: In single-point mode (`single_mode_i`=1), a tick that finds no unread conversion produces no output. The read is served, fresh, one cycle after the next accepted conversion. Several ticks that arrive while a read is waiting merge into one output.
- R9: In single-point mode every returned sample has `smp_fresh_o`=1.
- R10: A tick in the same cycle as a commit is ignored. A commit while a task is running returns the block to the pre-start state, so later conversions are discarded until the next start trigger.
- R11: With N ticks between successive conversions, each conversion yields exactly one fresh sample followed by N-1 repeats of the same data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_tick_i | input | 1 | Shared sample clock tick, one cycle wide |
| conv_done_i | input | 1 | Conversion finished strobe |
| conv_data_i | input | DATA_W | Conversion result, valid with `conv_done_i` |
| commit_i | input | 1 | Task commit pulse; takes the first point |
| start_i | input | 1 | Start trigger pulse |
| single_mode_i | input | 1 | 1 = single-point mode, no repeats |
| smp_data_o | output | DATA_W | Returned sample data |
| smp_valid_o | output | 1 | Sample returned this cycle |
| smp_fresh_o | output | 1 | 1 = new conversion, 0 = repeat |

## Verification
Every result is due in the cycle right after the clock edge that samples its cause. For a tick, that is the tick edge. For a waiting single-point read, it is the edge of the conversion that serves it. The driver changes inputs on falling edges. Each time it drives a tick or a serving conversion, it pushes the expected word and flag into a queue. The monitor samples on the following falling edge. It pops exactly one entry for each valid output and reports any valid output that arrives when no entry is waiting. Ticks that must stay silent (before commit, in the commit cycle, single-point waits) therefore show up as unexpected outputs, and a drained-queue check at the end of each step catches results that never arrived.

// File: rtl/srb_pkg.sv
package srb_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ARMED = 2'd1,
    PH_RUN   = 2'd2
  } phase_e;
endpackage

// File: rtl/srb_latest.sv
module srb_latest #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] conv_data_i,
  output logic [DATA_W-1:0] latest_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          latest_o <= '0;
    else if (conv_done_i) latest_o <= conv_data_i;
  end
endmodule

// File: rtl/srb_hold.sv
module srb_hold
  import srb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] conv_data_i,
  input  logic [DATA_W-1:0] latest_i,
  input  logic              commit_i,
  input  logic              start_i,
  input  logic              consume_i,
  output phase_e            phase_o,
  output logic              live_o,
  output logic [DATA_W-1:0] cur_data_o,
  output logic              cur_new_o,
  output logic [DATA_W-1:0] hold_o,
  output logic              unread_o
);
  phase_e            phase_q;
  logic [DATA_W-1:0] hold_q;
  logic              unread_q;
  logic              accept;

  // conversions only count once the task runs; commit wins the cycle
  assign accept     = conv_done_i && (phase_q == PH_RUN) && !commit_i;
  assign live_o     = (phase_q != PH_IDLE) && !commit_i;
  assign cur_data_o = accept ? conv_data_i : hold_q;
  assign cur_new_o  = accept || unread_q;
  assign phase_o    = phase_q;
  assign hold_o     = hold_q;
  assign unread_o   = unread_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      hold_q   <= '0;
      unread_q <= 1'b0;
    end else if (commit_i) begin
      phase_q  <= PH_ARMED;
      hold_q   <= conv_done_i ? conv_data_i : latest_i;
      unread_q <= 1'b1;
    end else begin
      if (start_i && phase_q == PH_ARMED) phase_q <= PH_RUN;
      if (accept) begin
        hold_q   <= conv_data_i;
        unread_q <= !consume_i;
      end else if (consume_i) begin
        unread_q <= 1'b0;
      end
    end
  end

  assert_start_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_ARMED && !commit_i) |=> $stable(hold_q));

endmodule

// File: rtl/srb_emit.sv
module srb_emit #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              single_i,
  input  logic              live_i,
  input  logic [DATA_W-1:0] cur_data_i,
  input  logic              cur_new_i,
  output logic              consume_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              fresh_o
);
  logic wait_q;
  logic want;
  logic emit;

  assign want      = tick_i || wait_q;
  assign emit      = live_i && (single_i ? (want && cur_new_i) : tick_i);
  assign consume_o = emit && cur_new_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q  <= 1'b0;
      valid_o <= 1'b0;
      fresh_o <= 1'b0;
      data_o  <= '0;
    end else begin
      wait_q  <= live_i && single_i && want && !cur_new_i;
      valid_o <= emit;
      if (emit) begin
        data_o  <= cur_data_i;
        fresh_o <= cur_new_i;
      end
    end
  end

  assert_wait_silent_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_q |-> !valid_o);

  assert_single_fresh_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(single_i)) |-> fresh_o);

endmodule

// File: rtl/slow_repeat_buf.sv
module slow_repeat_buf
  import srb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_tick_i,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] conv_data_i,
  input  logic              commit_i,
  input  logic              start_i,
  input  logic              single_mode_i,
  output logic [DATA_W-1:0] smp_data_o,
  output logic              smp_valid_o,
  output logic              smp_fresh_o
);
  logic [DATA_W-1:0] latest;
  logic [DATA_W-1:0] cur_data;
  logic [DATA_W-1:0] hold_q;
  logic              cur_new;
  logic              live;
  logic              consume;
  logic              unread_q;
  phase_e            phase;

  srb_latest #(.DATA_W(DATA_W)) u_latest (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .conv_done_i (conv_done_i),
    .conv_data_i (conv_data_i),
    .latest_o    (latest)
  );

  srb_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .conv_done_i (conv_done_i),
    .conv_data_i (conv_data_i),
    .latest_i    (latest),
    .commit_i    (commit_i),
    .start_i     (start_i),
    .consume_i   (consume),
    .phase_o     (phase),
    .live_o      (live),
    .cur_data_o  (cur_data),
    .cur_new_o   (cur_new),
    .hold_o      (hold_q),
    .unread_o    (unread_q)
  );

  srb_emit #(.DATA_W(DATA_W)) u_emit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (smp_tick_i),
    .single_i   (single_mode_i),
    .live_i     (live),
    .cur_data_i (cur_data),
    .cur_new_i  (cur_new),
    .consume_o  (consume),
    .data_o     (smp_data_o),
    .valid_o    (smp_valid_o),
    .fresh_o    (smp_fresh_o)
  );

  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_IDLE) |=> !smp_valid_o);

  assert_repeat_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_o && !smp_fresh_o) |-> (smp_data_o == hold_q));

  assert_fresh_taken_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_o && smp_fresh_o) |-> !unread_q);

endmodule

// File: tb/slow_repeat_buf_test.sv
module slow_repeat_buf_test;
  localparam int W = 16;

  typedef struct {
    logic [W-1:0] d;
    logic         f;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0, cdone = 1'b0, commit = 1'b0, start = 1'b0, single = 1'b0;
  logic [W-1:0] cdata = '0;
  logic [W-1:0] sdata;
  logic         svalid, sfresh;

  int    checks = 0;
  int    errors = 0;
  string cur_tag = "R1";
  exp_t  sb[$];

  always #10 clk = ~clk;

  slow_repeat_buf #(.DATA_W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .smp_tick_i(tick), .conv_done_i(cdone),
    .conv_data_i(cdata), .commit_i(commit), .start_i(start),
    .single_mode_i(single), .smp_data_o(sdata), .smp_valid_o(svalid),
    .smp_fresh_o(sfresh)
  );

  task automatic expect_out(input logic [W-1:0] d, input logic f);
    exp_t e;
    e.d = d; e.f = f; e.tag = cur_tag;
    sb.push_back(e);
  endtask

  // one cycle of stimulus, driven on the falling edge
  task automatic step(input logic t, input logic cd, input logic [W-1:0] dv,
                      input logic cm, input logic st);
    @(negedge clk);
    tick = t; cdone = cd; cdata = dv; commit = cm; start = st;
    @(posedge clk);
    @(negedge clk);
    tick = 0; cdone = 0; commit = 0; start = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drained(input string r);
    idle(2);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL %s: pending results actual %0d expected 0", r, sb.size());
      sb.delete();
    end
  endtask

  // monitor: one pop per valid output, sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n && svalid) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL %s: unexpected output actual %h/%0b expected none", cur_tag, sdata, sfresh);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (sdata !== e.d || sfresh !== e.f) begin
          errors++;
          $display("FAIL %s: actual %h/%0b expected %h/%0b", e.tag, sdata, sfresh, e.d, e.f);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (svalid !== 1'b0 || sfresh !== 1'b0 || sdata !== '0) begin
      errors++;
      $display("FAIL R1: actual %0b/%0b/%h expected 0/0/0000", svalid, sfresh, sdata);
    end
    rst_n = 1'b1;
    idle(2);
    checks++;
    if (svalid !== 1'b0 || sfresh !== 1'b0 || sdata !== '0) begin
      errors++;
      $display("FAIL R1: actual %0b/%0b/%h expected 0/0/0000", svalid, sfresh, sdata);
    end

    // R2 ticks before commit stay silent
    cur_tag = "R2";
    step(1, 0, '0, 0, 0);
    step(1, 1, 16'h0011, 0, 0);
    step(0, 1, 16'h0022, 0, 0);
    drained("R2");

    // R3 commit takes the latest conversion
    cur_tag = "R3";
    step(0, 0, '0, 1, 0);
    expect_out(16'h0022, 1); step(1, 0, '0, 0, 0);
    drained("R3");
    cur_tag = "R4";
    expect_out(16'h0022, 0); step(1, 0, '0, 0, 0);
    expect_out(16'h0022, 0); step(1, 0, '0, 0, 0);
    drained("R4");

    // R5 conversions before start are discarded
    cur_tag = "R5";
    step(0, 1, 16'h0033, 0, 0);
    expect_out(16'h0022, 0); step(1, 0, '0, 0, 0);
    step(0, 0, '0, 0, 1);
    expect_out(16'h0022, 0); step(1, 0, '0, 0, 0);
    drained("R5");

    // R6 conversion after start replaces the point
    cur_tag = "R6";
    step(0, 1, 16'h0044, 0, 0);
    idle(1);
    expect_out(16'h0044, 1); step(1, 0, '0, 0, 0);
    expect_out(16'h0044, 0); step(1, 0, '0, 0, 0);
    drained("R6");

    // R7 same-cycle conversion and tick
    cur_tag = "R7";
    expect_out(16'h0055, 1); step(1, 1, 16'h0055, 0, 0);
    expect_out(16'h0055, 0); step(1, 0, '0, 0, 0);
    drained("R7");

    // R11 ten ticks per conversion
    cur_tag = "R11";
    for (int k = 0; k < 3; k++) begin
      logic [W-1:0] v;
      v = 16'h0100 + W'(k);
      step(0, 1, v, 0, 0);
      for (int j = 0; j < 10; j++) begin
        expect_out(v, j == 0);
        step(1, 0, '0, 0, 0);
      end
    end
    drained("R11");

    // R8 / R9 single-point mode
    cur_tag = "R8";
    single = 1'b1;
    step(1, 0, '0, 0, 0);
    step(1, 0, '0, 0, 0);
    idle(3);
    expect_out(16'h0066, 1); step(0, 1, 16'h0066, 0, 0);
    drained("R8");
    cur_tag = "R9";
    step(0, 1, 16'h0077, 0, 0);
    expect_out(16'h0077, 1); step(1, 0, '0, 0, 0);
    step(1, 0, '0, 0, 0);
    expect_out(16'h0088, 1); step(1, 1, 16'h0088, 0, 0);
    drained("R9");

    // R10 re-commit: tick in commit cycle ignored, back to pre-start
    cur_tag = "R10";
    single = 1'b0;
    step(1, 0, '0, 1, 0);
    step(0, 1, 16'h0099, 0, 0);
    expect_out(16'h0088, 1); step(1, 0, '0, 0, 0);
    expect_out(16'h0088, 0); step(1, 0, '0, 0, 0);
    step(0, 1, 16'h00aa, 0, 0);
    expect_out(16'h0088, 0); step(1, 0, '0, 0, 0);
    drained("R10");

    // R3 commit with a same-cycle conversion
    cur_tag = "R3";
    step(0, 1, 16'h00bb, 1, 0);
    expect_out(16'h00bb, 1); step(1, 0, '0, 0, 0);
    drained("R3");

    idle(4);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule